// File: doc/BRIEF.md
# Slave-Serial Configuration Sequencer

This block brings up a target FPGA that configures over a bit-serial link. On a start request it turns on the target's supply, lets it settle, pulses the active-low program line, and then waits for the target to release its active-low init line. Once init is released, it pulls bytes one by one from a ready/valid byte source and shifts each byte onto the data pin, most significant bit first. Each bit is followed by one pulse on the configuration clock. After the last byte it keeps pulsing the clock until the target raises done.

Both waits are bounded. If init never rises or done never arrives, the block stops and raises an error flag. The block also remembers the identifier of the image it last loaded successfully. A request for that same image completes at once and leaves the pins untouched. All delays and clock widths are counted in system clock cycles and are set by parameters.

Top module: `cfg_loader`

## Requirements
- R1: After reset, power_en_o=0, prog_n_o=1, cclk_o=0, din_o=0, byte_ready_o=0, and busy_o, ok_o and error_o are all 0. While busy_o=0, cclk_o stays 0 and prog_n_o stays 1.
- R2: A start_i sampled while idle, whose image_id_i differs from the remembered image (or when no image is remembered), does three things on the next edge: it sets busy_o and power_en_o to 1 and clears ok_o and error_o. prog_n_o then stays 1 for SETTLE_CYC cycles, goes 0 for exactly PROG_LOW_CYC cycles, and returns to 1.
- R3: After prog_n_o returns high, init_n_i is polled once per cycle. If it is still 0 on INIT_POLLS consecutive polls, the load ends with error_o=1 and no clock pulse is issued.
- R4: Each byte is sent bit 7 first down to bit 0. For each bit, din_o is set with cclk_o low, held for CCLK_LO_CYC cycles, and then cclk_o is high for CCLK_HI_CYC cycles. din_o does not change while cclk_o is high.
- R5: byte_ready_o=1 only while the block waits for the next byte. A byte is taken on an edge where byte_ready_o=1, byte_valid_i=1 and byte_err_i=0. Exactly image_len_i bytes are taken, and a length of 0 takes none.
- R6: A byte_err_i=1 seen while byte_ready_o=1 ends the load with error_o=1 and takes no further bytes.
- R7: After the data, done_i is sampled at the end of each clock-low phase. If it is 1, the load succeeds. Otherwise one extra clock pulse is issued. Once DONE_PULSES extra pulses have been issued without done_i, the load ends with error_o=1.
- R8: A successful load ends with busy_o=0 and ok_o=1, and its identifier becomes the remembered image.
- R9: A start_i sampled while idle whose image_id_i equals the remembered image sets ok_o=1 on the next edge. busy_o stays 0, no byte is taken and no pin changes.
- R10: A failed load leaves the remembered image unchanged. error_o stays 1 until the next start_i.
- R11: start_i has no effect while busy_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load request, sampled while idle |
| image_id_i | input | ID_W | Identifier of the requested image |
| image_len_i | input | LEN_W | Number of image bytes to send |
| byte_valid_i | input | 1 | Byte source has data |
| byte_data_i | input | DATA_W | Byte from the source |
| byte_err_i | input | 1 | Byte source reports a failure |
| byte_ready_o | output | 1 | Block waits for a byte |
| power_en_o | output | 1 | Target supply enable |
| prog_n_o | output | 1 | Active-low program line to target |
| cclk_o | output | 1 | Configuration clock to target |
| din_o | output | 1 | Serial configuration data to target |
| init_n_i | input | 1 | Target init line, high when ready for data |
| done_i | input | 1 | Target done line |
| busy_o | output | 1 | Load in progress |
| ok_o | output | 1 | Last request completed successfully |
| error_o | output | 1 | Last load failed |

## Verification
The assertions watch, on every cycle, the relations that never depend on timing: the program pulse happens only while powered and busy, data holds still across a clock-high phase, the block asks for bytes only mid-load, ok and error are never both set, an error holds until a start, and the pins stay quiet when idle. The exact lengths of the settle and program phases, the bit order, the byte count, the number of extra clock pulses and the two timeout limits can only be shown by the bench's scenarios. The bench compares every output on every cycle against its behavioural model, and it also reassembles the bytes it saw on the pins. The cache-hit path and the rule that a failure keeps the remembered image are likewise scenario checks.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_SETTLE = 4'd1,
        ST_PROG   = 4'd2,
        ST_INIT   = 4'd3,
        ST_FETCH  = 4'd4,
        ST_BLO    = 4'd5,
        ST_BHI    = 4'd6,
        ST_FLO    = 4'd7,
        ST_FHI    = 4'd8
    } ld_state_e;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // bits needed to hold values 0..v
    function automatic int unsigned cnt_bits(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/cfg_dwell_timer.sv
module cfg_dwell_timer #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/cfg_limit_counter.sv
module cfg_limit_counter #(
    parameter int unsigned W     = 4,
    parameter int unsigned LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic hit_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit_o = (cnt_q == W'(LIMIT));
endmodule

// File: rtl/cfg_bit_shifter.sv
module cfg_bit_shifter #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] data_i,
    input  logic          shift_i,
    output logic          next_bit_o,
    output logic          last_o
);
    localparam int unsigned IW = cfg_loader_pkg::cnt_bits(DW - 1);

    logic [DW-1:0] sreg_q;
    logic [IW-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            idx_q  <= '0;
        end else if (load_i) begin
            sreg_q <= data_i;
            idx_q  <= '0;
        end else if (shift_i) begin
            sreg_q <= {sreg_q[DW-2:0], 1'b0};
            idx_q  <= idx_q + 1'b1;
        end
    end

    // bit that follows the one currently on the pin
    assign next_bit_o = sreg_q[DW-2];
    assign last_o     = (idx_q == IW'(DW - 1));
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int unsigned ID_W         = 4,
    parameter int unsigned LEN_W        = 24,
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned SETTLE_CYC   = 1200000,
    parameter int unsigned PROG_LOW_CYC = 1200000,
    parameter int unsigned CCLK_HI_CYC  = 2,
    parameter int unsigned CCLK_LO_CYC  = 2,
    parameter int unsigned INIT_POLLS   = 100000,
    parameter int unsigned DONE_PULSES  = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ID_W-1:0]   image_id_i,
    input  logic [LEN_W-1:0]  image_len_i,
    input  logic              byte_valid_i,
    input  logic [DATA_W-1:0] byte_data_i,
    input  logic              byte_err_i,
    output logic              byte_ready_o,
    output logic              power_en_o,
    output logic              prog_n_o,
    output logic              cclk_o,
    output logic              din_o,
    input  logic              init_n_i,
    input  logic              done_i,
    output logic              busy_o,
    output logic              ok_o,
    output logic              error_o
);
    localparam int unsigned DLY_MAX = max_of(max_of(SETTLE_CYC, PROG_LOW_CYC),
                                             max_of(CCLK_HI_CYC, CCLK_LO_CYC));
    localparam int unsigned TMR_W   = cnt_bits(DLY_MAX);
    localparam int unsigned POLL_W  = cnt_bits(INIT_POLLS);
    localparam int unsigned PULSE_W = cnt_bits(DONE_PULSES);

    localparam logic [TMR_W-1:0] T_SETTLE = TMR_W'(SETTLE_CYC - 1);
    localparam logic [TMR_W-1:0] T_PROG   = TMR_W'(PROG_LOW_CYC - 1);
    localparam logic [TMR_W-1:0] T_HI     = TMR_W'(CCLK_HI_CYC - 1);
    localparam logic [TMR_W-1:0] T_LO     = TMR_W'(CCLK_LO_CYC - 1);

    typedef struct packed {
        ld_state_e        st;
        logic             pwr;
        logic             prog_n;
        logic             cclk;
        logic             din;
        logic             busy;
        logic             ok;
        logic             err;
        logic             have;
        logic [ID_W-1:0]  img;
        logic [ID_W-1:0]  cur;
        logic [LEN_W-1:0] left;
    } ctl_t;

    ctl_t r_q, r_d;

    logic             tmr_load, tmr_done;
    logic [TMR_W-1:0] tmr_val;
    logic             poll_clr, poll_inc, poll_hit;
    logic             pulse_clr, pulse_inc, pulse_hit;
    logic             sh_load, sh_shift, sh_next, sh_last;

    cfg_dwell_timer #(.W(TMR_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .load_val_i(tmr_val),
        .expired_o (tmr_done)
    );

    cfg_limit_counter #(.W(POLL_W), .LIMIT(INIT_POLLS - 1)) u_poll_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr_i(poll_clr),
        .inc_i(poll_inc),
        .hit_o(poll_hit)
    );

    cfg_limit_counter #(.W(PULSE_W), .LIMIT(DONE_PULSES)) u_pulse_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr_i(pulse_clr),
        .inc_i(pulse_inc),
        .hit_o(pulse_hit)
    );

    cfg_bit_shifter #(.DW(DATA_W)) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (sh_load),
        .data_i    (byte_data_i),
        .shift_i   (sh_shift),
        .next_bit_o(sh_next),
        .last_o    (sh_last)
    );

    always_comb begin
        r_d       = r_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        poll_clr  = 1'b0;
        poll_inc  = 1'b0;
        pulse_clr = 1'b0;
        pulse_inc = 1'b0;
        sh_load   = 1'b0;
        sh_shift  = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (r_q.have && (image_id_i == r_q.img)) begin
                        r_d.ok  = 1'b1;
                        r_d.err = 1'b0;
                    end else begin
                        r_d.busy = 1'b1;
                        r_d.ok   = 1'b0;
                        r_d.err  = 1'b0;
                        r_d.pwr  = 1'b1;
                        r_d.cur  = image_id_i;
                        r_d.left = image_len_i;
                        r_d.st   = ST_SETTLE;
                        tmr_load = 1'b1;
                        tmr_val  = T_SETTLE;
                    end
                end
            end
            ST_SETTLE: begin
                if (tmr_done) begin
                    r_d.prog_n = 1'b0;
                    r_d.st     = ST_PROG;
                    tmr_load   = 1'b1;
                    tmr_val    = T_PROG;
                end
            end
            ST_PROG: begin
                if (tmr_done) begin
                    r_d.prog_n = 1'b1;
                    r_d.st     = ST_INIT;
                    poll_clr   = 1'b1;
                end
            end
            ST_INIT: begin
                if (init_n_i) begin
                    if (r_q.left == '0) begin
                        r_d.st    = ST_FLO;
                        tmr_load  = 1'b1;
                        tmr_val   = T_LO;
                        pulse_clr = 1'b1;
                    end else begin
                        r_d.st = ST_FETCH;
                    end
                end else if (poll_hit) begin
                    r_d.st   = ST_IDLE;
                    r_d.busy = 1'b0;
                    r_d.err  = 1'b1;
                end else begin
                    poll_inc = 1'b1;
                end
            end
            ST_FETCH: begin
                if (byte_err_i) begin
                    r_d.st   = ST_IDLE;
                    r_d.busy = 1'b0;
                    r_d.err  = 1'b1;
                    r_d.din  = 1'b0;
                end else if (byte_valid_i) begin
                    sh_load  = 1'b1;
                    r_d.din  = byte_data_i[DATA_W-1];
                    r_d.left = r_q.left - 1'b1;
                    r_d.st   = ST_BLO;
                    tmr_load = 1'b1;
                    tmr_val  = T_LO;
                end
            end
            ST_BLO: begin
                if (tmr_done) begin
                    r_d.cclk = 1'b1;
                    r_d.st   = ST_BHI;
                    tmr_load = 1'b1;
                    tmr_val  = T_HI;
                end
            end
            ST_BHI: begin
                if (tmr_done) begin
                    r_d.cclk = 1'b0;
                    if (!sh_last) begin
                        sh_shift = 1'b1;
                        r_d.din  = sh_next;
                        r_d.st   = ST_BLO;
                        tmr_load = 1'b1;
                        tmr_val  = T_LO;
                    end else if (r_q.left == '0) begin
                        r_d.st    = ST_FLO;
                        tmr_load  = 1'b1;
                        tmr_val   = T_LO;
                        pulse_clr = 1'b1;
                    end else begin
                        r_d.st = ST_FETCH;
                    end
                end
            end
            ST_FLO: begin
                if (tmr_done) begin
                    if (done_i) begin
                        r_d.st   = ST_IDLE;
                        r_d.busy = 1'b0;
                        r_d.ok   = 1'b1;
                        r_d.din  = 1'b0;
                        r_d.have = 1'b1;
                        r_d.img  = r_q.cur;
                    end else if (pulse_hit) begin
                        r_d.st   = ST_IDLE;
                        r_d.busy = 1'b0;
                        r_d.err  = 1'b1;
                        r_d.din  = 1'b0;
                    end else begin
                        r_d.cclk  = 1'b1;
                        pulse_inc = 1'b1;
                        r_d.st    = ST_FHI;
                        tmr_load  = 1'b1;
                        tmr_val   = T_HI;
                    end
                end
            end
            ST_FHI: begin
                if (tmr_done) begin
                    r_d.cclk = 1'b0;
                    r_d.st   = ST_FLO;
                    tmr_load = 1'b1;
                    tmr_val  = T_LO;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= ST_IDLE;
            r_q.prog_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign byte_ready_o = (r_q.st == ST_FETCH);
    assign power_en_o   = r_q.pwr;
    assign prog_n_o     = r_q.prog_n;
    assign cclk_o       = r_q.cclk;
    assign din_o        = r_q.din;
    assign busy_o       = r_q.busy;
    assign ok_o         = r_q.ok;
    assign error_o      = r_q.err;
endmodule

// File: rtl/cfg_loader_sva.sv
module cfg_loader_sva (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic byte_ready_o,
    input logic power_en_o,
    input logic prog_n_o,
    input logic cclk_o,
    input logic din_o,
    input logic busy_o,
    input logic ok_o,
    input logic error_o
);
    AST_IDLE_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!cclk_o && prog_n_o && !byte_ready_o))
        else $error("idle pins not quiet"); // R1

    AST_PROG_PULSE_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n_o |-> (busy_o && power_en_o))
        else $error("program pulse outside a powered load"); // R2

    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i))
        else $error("load began without a start"); // R2

    AST_DIN_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cclk_o && $past(cclk_o)) |-> $stable(din_o))
        else $error("data moved while clock high"); // R4

    AST_READY_MID_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready_o |-> (busy_o && prog_n_o && !cclk_o))
        else $error("byte requested outside data phase"); // R5

    AST_OUTCOME_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok_o && error_o) && !(busy_o && (ok_o || error_o)))
        else $error("outcome flags overlap"); // R8

    AST_ERROR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (error_o && !start_i) |=> error_o)
        else $error("error dropped without a start"); // R10
endmodule

bind cfg_loader cfg_loader_sva u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .byte_ready_o(byte_ready_o),
    .power_en_o  (power_en_o),
    .prog_n_o    (prog_n_o),
    .cclk_o      (cclk_o),
    .din_o       (din_o),
    .busy_o      (busy_o),
    .ok_o        (ok_o),
    .error_o     (error_o)
);

// File: tb/cfg_loader_tb_top.sv
`timescale 1ns/1ps
module cfg_loader_tb_top;
    localparam int P_SETTLE = 4;
    localparam int P_PROG   = 3;
    localparam int P_HI     = 2;
    localparam int P_LO     = 2;
    localparam int P_INIT   = 20;
    localparam int P_DONE   = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [3:0] image_id_i = '0;
    logic [7:0] image_len_i = '0;
    logic       byte_valid_i = 1'b0;
    logic [7:0] byte_data_i = '0;
    logic       byte_err_i = 1'b0;
    logic       init_n_i = 1'b0;
    logic       done_i = 1'b0;
    logic       byte_ready_o, power_en_o, prog_n_o, cclk_o, din_o;
    logic       busy_o, ok_o, error_o;

    always #2.5 clk = ~clk;

    cfg_loader #(
        .ID_W(4), .LEN_W(8), .DATA_W(8),
        .SETTLE_CYC(P_SETTLE), .PROG_LOW_CYC(P_PROG),
        .CCLK_HI_CYC(P_HI), .CCLK_LO_CYC(P_LO),
        .INIT_POLLS(P_INIT), .DONE_PULSES(P_DONE)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .image_id_i(image_id_i), .image_len_i(image_len_i),
        .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i),
        .byte_err_i(byte_err_i), .byte_ready_o(byte_ready_o),
        .power_en_o(power_en_o), .prog_n_o(prog_n_o), .cclk_o(cclk_o),
        .din_o(din_o), .init_n_i(init_n_i), .done_i(done_i),
        .busy_o(busy_o), .ok_o(ok_o), .error_o(error_o)
    );

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;

    // environment configuration, written by the scenario tasks
    int cfg_init = 0;     // polls before init rises, -1 never
    int cfg_target = 0;   // cclk rises before done, -1 never
    int cfg_err = -1;     // byte index that reports an error
    bit cfg_stall = 1'b0;
    logic [7:0] src [0:7];

    int cyc = 0;
    int acc_cnt = 0, base_acc = 0;
    int rise_tot = 0, rise_since = 0, init_cnt = 0, prog_low_tot = 0;
    bit cap [0:1023];
    logic cclk_prev = 1'b0;

    // expected outputs from the behavioural model
    logic e_ready = 0, e_pwr = 0, e_prog = 1, e_cclk = 0, e_din = 0;
    logic e_busy = 0, e_ok = 0, e_err = 0;
    bit   m_have = 0;
    int   m_id = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // accepted bytes, sampled with the design at the edge
    always @(posedge clk) begin
        if (rst_n && byte_ready_o && byte_valid_i && !byte_err_i) acc_cnt++;
    end

    // target and byte-source behaviour, driven away from the edge
    always @(negedge clk) begin
        cyc++;
        if (cclk_o && !cclk_prev) begin
            cap[rise_tot % 1024] = din_o;
            rise_tot++;
            rise_since++;
        end
        cclk_prev = cclk_o;
        if (!prog_n_o) begin
            init_cnt = 0;
            rise_since = 0;
            prog_low_tot++;
        end else begin
            init_cnt++;
        end
        init_n_i     = (cfg_init >= 0) && (init_cnt > cfg_init);
        done_i       = (cfg_target >= 0) && prog_n_o && (rise_since >= cfg_target);
        byte_valid_i = cfg_stall ? (cyc % 3 == 0) : 1'b1;
        byte_data_i  = src[(acc_cnt - base_acc) % 8];
        byte_err_i   = (cfg_err >= 0) && ((acc_cnt - base_acc) == cfg_err);
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_en) begin
            checks++;
            if (byte_ready_o !== e_ready) begin errors++; $display("FAIL R5 byte_ready_o actual %0b expected %0b", byte_ready_o, e_ready); end
            if (power_en_o !== e_pwr)     begin errors++; $display("FAIL R2 power_en_o actual %0b expected %0b", power_en_o, e_pwr); end
            if (prog_n_o !== e_prog)      begin errors++; $display("FAIL R2 prog_n_o actual %0b expected %0b", prog_n_o, e_prog); end
            if (cclk_o !== e_cclk)        begin errors++; $display("FAIL R4 cclk_o actual %0b expected %0b", cclk_o, e_cclk); end
            if (din_o !== e_din)          begin errors++; $display("FAIL R4 din_o actual %0b expected %0b", din_o, e_din); end
            if (busy_o !== e_busy)        begin errors++; $display("FAIL R8 busy_o actual %0b expected %0b", busy_o, e_busy); end
            if (ok_o !== e_ok)            begin errors++; $display("FAIL R8 ok_o actual %0b expected %0b", ok_o, e_ok); end
            if (error_o !== e_err)        begin errors++; $display("FAIL R10 error_o actual %0b expected %0b", error_o, e_err); end
        end
    end

    // behavioural model: a procedural walk through one load
    task automatic m_fail();
        e_busy = 0; e_err = 1; e_ready = 0; e_din = 0; e_cclk = 0;
    endtask

    task automatic m_load(input int id, input int len);
        logic [7:0] b;
        int n;
        e_busy = 1; e_ok = 0; e_err = 0; e_pwr = 1;
        repeat (P_SETTLE) @(posedge clk);
        e_prog = 0;
        repeat (P_PROG) @(posedge clk);
        e_prog = 1;
        n = 0;
        forever begin
            @(posedge clk);
            if (init_n_i) break;
            if (n == P_INIT - 1) begin m_fail(); return; end
            n++;
        end
        for (int k = 0; k < len; k++) begin
            e_ready = 1;
            forever begin
                @(posedge clk);
                if (byte_err_i) begin m_fail(); return; end
                if (byte_valid_i) break;
            end
            e_ready = 0;
            b = byte_data_i;
            e_din = b[7];
            for (int i = 7; i >= 0; i--) begin
                repeat (P_LO) @(posedge clk);
                e_cclk = 1;
                repeat (P_HI) @(posedge clk);
                e_cclk = 0;
                if (i > 0) e_din = b[i-1];
            end
        end
        n = 0;
        forever begin
            repeat (P_LO) @(posedge clk);
            if (done_i) begin
                e_busy = 0; e_ok = 1; e_din = 0;
                m_have = 1; m_id = id;
                return;
            end
            if (n == P_DONE) begin m_fail(); return; end
            e_cclk = 1;
            n++;
            repeat (P_HI) @(posedge clk);
            e_cclk = 0;
        end
    endtask

    initial begin
        wait (rst_n === 1'b1);
        forever begin
            @(posedge clk);
            if (start_i) begin
                if (m_have && (int'(image_id_i) == m_id)) begin
                    e_ok = 1; e_err = 0;
                end else begin
                    m_load(int'(image_id_i), int'(image_len_i));
                end
            end
        end
    end

    // scenario helpers
    task automatic pulse_start(input int id, input int len);
        @(negedge clk);
        start_i = 1'b1;
        image_id_i = 4'(id);
        image_len_i = 8'(len);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            if (!busy_o) break;
            @(negedge clk);
        end
    endtask

    task automatic run_load(input string req, input int id, input int len,
                            input int init_dly, input int target, input int err_at,
                            input bit stall, input bit poke_busy,
                            input int exp_ok, input int exp_bytes, input int exp_rises);
        int r0, p0;
        cfg_init = init_dly; cfg_target = target; cfg_err = err_at; cfg_stall = stall;
        base_acc = acc_cnt;
        r0 = rise_tot;
        p0 = prog_low_tot;
        pulse_start(id, len);
        chk(req, "busy after start", int'(busy_o), 1);
        if (poke_busy) begin
            repeat (12) @(negedge clk);
            // R11: a start with another id while busy must be ignored
            pulse_start(9, 5);
        end
        wait_idle();
        @(negedge clk);
        chk(req, "ok_o", int'(ok_o), exp_ok);
        chk(req, "error_o", int'(error_o), 1 - exp_ok);
        chk("R5", "bytes taken", acc_cnt - base_acc, exp_bytes);
        chk("R7", "clock rises", rise_tot - r0, exp_rises);
        chk("R2", "prog low cycles", prog_low_tot - p0, P_PROG);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R1", "power_en_o", int'(power_en_o), 0);
        chk("R1", "prog_n_o", int'(prog_n_o), 1);
        chk("R1", "cclk_o/din_o", int'({cclk_o, din_o}), 0);
        chk("R1", "busy/ok/err/ready", int'({busy_o, ok_o, error_o, byte_ready_o}), 0);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        repeat (3) @(negedge clk);

        // R2 R3 R4 R5 R7 R8 R11: full load with a stalled source
        src[0] = 8'hA5; src[1] = 8'h3C; src[2] = 8'h81;
        begin
            int r0;
            r0 = rise_tot;
            run_load("R8", 1, 3, 5, 27, -1, 1'b1, 1'b1, 1, 3, 27);
            for (int k = 0; k < 3; k++) begin
                logic [7:0] got;
                for (int i = 0; i < 8; i++) got[7-i] = cap[(r0 + 8*k + i) % 1024];
                chk("R4", "byte on din", int'(got), int'(src[k]));
            end
        end

        // R9: same identifier completes at once
        begin
            int a0, r0;
            a0 = acc_cnt; r0 = rise_tot;
            pulse_start(1, 3);
            chk("R9", "ok_o next cycle", int'(ok_o), 1);
            chk("R9", "busy_o stays low", int'(busy_o), 0);
            repeat (4) @(negedge clk);
            chk("R9", "no bytes taken", acc_cnt - a0, 0);
            chk("R9", "no clock rises", rise_tot - r0, 0);
        end

        // R3: init never rises
        run_load("R3", 2, 2, -1, 16, -1, 1'b0, 1'b0, 0, 0, 0);
        repeat (6) @(negedge clk);
        chk("R10", "error held", int'(error_o), 1);
        // R10: remembered image still 1
        pulse_start(1, 3);
        chk("R10", "hit after failure", int'(ok_o), 1);
        chk("R10", "error cleared by start", int'(error_o), 0);

        // R6: source error on the second byte
        src[0] = 8'h11; src[1] = 8'h22; src[2] = 8'h33;
        run_load("R6", 2, 3, 2, 25, 1, 1'b0, 1'b0, 0, 1, 8);

        // R7: done never arrives
        src[0] = 8'hF0; src[1] = 8'h0F;
        run_load("R7", 3, 2, 0, -1, -1, 1'b0, 1'b0, 0, 2, 16 + P_DONE);

        // R5 R7: zero-length image with done already high
        run_load("R5", 3, 0, 1, 0, -1, 1'b0, 1'b0, 1, 0, 0);
        pulse_start(3, 0);
        chk("R9", "hit on id 3", int'(ok_o), 1);

        // R11: id 9 poked during the first load was never remembered
        src[0] = 8'h5A;
        run_load("R11", 9, 1, 3, 10, -1, 1'b0, 1'b0, 1, 1, 10);

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog: busy_o actual %0b expected 0", busy_o);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule